// File: doc/BRIEF.md
# Control Register Bank with Set, Clear and Invert Aliases

This block is a small slice of memory-mapped control registers. Software reaches each register through four word addresses. The first is the register itself, for plain reads and writes. The other three are write-only aliases. One forces bits to one, one forces them to zero, and one flips them. The mask travels in the write data, so a single bus write changes chosen bits without a read-modify-write sequence that other agents could interleave with.

Each register has a mask of implemented bits. Bits outside it always read zero and ignore writes. Register 0 also carries one read-only status bit, taken from a hardware input. Software writes through any address cannot touch it. All register values leave the block on a flat output bus, to drive other logic.

Read data is registered. It appears in the cycle after the read request and holds until the next request. A write in the same cycle as a read only takes effect after that read has sampled the register.

Top module: `reg_alias_bank`

## Requirements
- R1: Reset is synchronous and active high. The cycle after reset, every register value and the read data are zero.
- R2: A write to a register's base address (offset 0x0) loads its implemented, writable bits from the write data. A read of the base address returns the register value on `bus_rdata` one cycle after the read request. `bus_rdata` holds its value while no read is requested.
- R3: A write to base plus 0x4 (address bits [3:2] = 1) clears each writable bit that has a 1 in the write data. Bits with a 0 in the write data are left unchanged.
- R4: A write to base plus 0x8 (address bits [3:2] = 2) sets each writable bit that has a 1 in the write data. Other bits are unchanged.
- R5: A write to base plus 0xC (address bits [3:2] = 3) inverts each writable bit that has a 1 in the write data. Other bits are unchanged.
- R6: A read of any of the three alias addresses returns zero.
- R7: Register i implements bits [BASE_BITS-1-SHRINK*i : 0], which is bits [15-4i:0] with the default parameters. All higher bits read zero on both `bus_rdata` and `ctrl_out`, whatever is written.
- R8: Bit 15 of register 0 is a read-only status bit. It equals `hw_status` delayed by one clock. No write through any of the four addresses changes it.
- R9: The register index is byte-address bits [ADDR_W-1:4], a 0x10 stride. A write to an index at or beyond NUM_REGS changes no register, and a read of such an index returns zero.
- R10: When a read and a write hit the same register in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W-2 | Word address, which is byte-address bits [ADDR_W-1:2] |
| bus_wr | input | 1 | Write request |
| bus_wdata | input | DATA_W | Write data or alias bit mask |
| bus_rd | input | 1 | Read request |
| bus_rdata | output | DATA_W | Registered read data |
| hw_status | input | 1 | Hardware status level, mirrored into register 0 |
| ctrl_out | output | NUM_REGS*DATA_W | All register values; register i at bits [i*DATA_W +: DATA_W] |

## Verification
On every cycle, the assertions check the following:
- Unimplemented bits stay zero.
- Each alias write leaves exactly the masked bits cleared, set or flipped in the next cycle.
- A register not addressed by a write keeps its writable bits.
- The status bit follows its input.
- Alias and out-of-range reads return zero.

Only the bench scenarios can show a few other properties. Address decode must pick the right register among several. Base writes must merge correctly with the status bit. A read that coincides with a write must return the old value. A long stream of mixed operations must agree with the bench's own model.

// File: rtl/ra_pkg.sv
package ra_pkg;

    // Alias operation, decoded from byte-address bits [3:2]
    typedef enum logic [1:0] {
        OP_BASE = 2'd0,
        OP_CLR  = 2'd1,
        OP_SET  = 2'd2,
        OP_INV  = 2'd3
    } alias_op_e;

    typedef struct packed {
        logic      in_range;
        alias_op_e op;
    } addr_dec_t;

    // Mask of implemented bits for register idx: a run of ones from bit 0
    function automatic logic [63:0] impl_mask_f(input int idx, input int base_bits,
                                                input int shrink);
        int width;
        width = base_bits - shrink * idx;
        if (width < 1) width = 1;
        if (width > 63) width = 63;
        return (64'd1 << width) - 64'd1;
    endfunction

    // Combine the stored writable bits with the bus mask according to the op
    function automatic logic [63:0] apply_op_f(input alias_op_e op, input logic [63:0] cur,
                                               input logic [63:0] wd, input logic [63:0] wm);
        logic [63:0] m;
        m = wd & wm;
        unique case (op)
            OP_BASE: return (cur & ~wm) | m;
            OP_CLR:  return cur & ~m;
            OP_SET:  return cur | m;
            default: return cur ^ m;
        endcase
    endfunction

endpackage

// File: rtl/alias_addr_decode.sv
module alias_addr_decode
    import ra_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_REGS = 4,
    localparam int IDX_W   = ADDR_W - 4
) (
    input  logic [ADDR_W-1:2] addr,
    output logic [IDX_W-1:0]  idx,
    output addr_dec_t         dec
);
    always_comb begin
        idx          = addr[ADDR_W-1:4];
        dec.op       = alias_op_e'(addr[3:2]);
        dec.in_range = (32'(addr[ADDR_W-1:4]) < NUM_REGS);
    end
endmodule

// File: rtl/alias_bit_update.sv
module alias_bit_update
    import ra_pkg::*;
#(
    parameter int                 DATA_W     = 32,
    parameter logic [DATA_W-1:0]  IMPL       = '1,
    parameter bit                 HAS_STATUS = 1'b0,
    parameter int                 STATUS_BIT = 15,
    localparam logic [DATA_W-1:0] STAT_M     = HAS_STATUS ? (DATA_W'(1) << STATUS_BIT) : '0,
    localparam logic [DATA_W-1:0] WMASK      = IMPL & ~STAT_M
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  alias_op_e         op,
    input  logic [DATA_W-1:0] wdata,
    input  logic              status_in,
    output logic [DATA_W-1:0] value
);
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] q_next;
    logic [DATA_W-1:0] stat_v;

    always_comb begin
        q_next = q;
        if (sel)
            q_next = DATA_W'(apply_op_f(op, 64'(q), 64'(wdata), 64'(WMASK)));
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_next & WMASK;
    end

    generate
        if (HAS_STATUS) begin : g_stat
            logic stat_q;
            always_ff @(posedge clk) begin
                if (rst) stat_q <= 1'b0;
                else     stat_q <= status_in;
            end
            assign stat_v = stat_q ? STAT_M : '0;

            // R8
            status_follow_chk: assert property (@(posedge clk) disable iff (rst)
                $past(!rst) |-> (value[STATUS_BIT] == $past(status_in)));
        end else begin : g_nostat
            assign stat_v = '0;
        end
    endgenerate

    assign value = q | stat_v;

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (value == '0));
    // R7
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (value & ~IMPL) == '0);
    // R3
    clr_effect_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(sel) && $past(op) == OP_CLR) |->
        ((value & $past(wdata) & WMASK) == '0));
    // R4
    set_effect_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(sel) && $past(op) == OP_SET) |->
        ((value & $past(wdata) & WMASK) == ($past(wdata) & WMASK)));
    // R5
    inv_effect_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(sel) && $past(op) == OP_INV) |->
        (((value ^ $past(value)) & WMASK) == ($past(wdata) & WMASK)));
    // R3
    alias_keep_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(sel) && $past(op) != OP_BASE) |->
        (((value ^ $past(value)) & WMASK & ~$past(wdata)) == '0));
    // R9
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(sel)) |-> ((value & WMASK) == ($past(value) & WMASK)));
endmodule

// File: rtl/alias_read_port.sv
module alias_read_port
    import ra_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 4,
    parameter int IDX_W    = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rd,
    input  logic [IDX_W-1:0]           idx,
    input  addr_dec_t                  dec,
    input  logic [NUM_REGS*DATA_W-1:0] values,
    output logic [DATA_W-1:0]          rdata
);
    logic [DATA_W-1:0] sel_v;

    always_comb begin
        sel_v = '0;
        if (dec.in_range && dec.op == OP_BASE) begin
            for (int i = 0; i < NUM_REGS; i++)
                if (idx == IDX_W'(i)) sel_v = values[i*DATA_W +: DATA_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= sel_v;
    end

    // R6
    alias_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(rd) && $past(dec.op) != OP_BASE) |-> (rdata == '0));
    // R9
    range_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(rd) && !$past(dec.in_range)) |-> (rdata == '0));
    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(rd)) |-> $stable(rdata));
endmodule

// File: rtl/reg_alias_bank.sv
module reg_alias_bank
    import ra_pkg::*;
#(
    parameter int NUM_REGS   = 4,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8,
    parameter int BASE_BITS  = 16,
    parameter int SHRINK     = 4,
    parameter int STATUS_BIT = 15,
    localparam int IDX_W     = ADDR_W - 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:2]          bus_addr,
    input  logic                       bus_wr,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic                       bus_rd,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic                       hw_status,
    output logic [NUM_REGS*DATA_W-1:0] ctrl_out
);
    logic [IDX_W-1:0] idx;
    addr_dec_t        dec;

    alias_addr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
        .addr (bus_addr),
        .idx  (idx),
        .dec  (dec)
    );

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            localparam logic [DATA_W-1:0] IM = DATA_W'(impl_mask_f(g, BASE_BITS, SHRINK));
            logic sel;
            assign sel = bus_wr && dec.in_range && (idx == IDX_W'(g));

            alias_bit_update #(
                .DATA_W     (DATA_W),
                .IMPL       (IM),
                .HAS_STATUS (g == 0),
                .STATUS_BIT (STATUS_BIT)
            ) u_upd (
                .clk       (clk),
                .rst       (rst),
                .sel       (sel),
                .op        (dec.op),
                .wdata     (bus_wdata),
                .status_in (hw_status),
                .value     (ctrl_out[g*DATA_W +: DATA_W])
            );
        end
    endgenerate

    alias_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rd (
        .clk    (clk),
        .rst    (rst),
        .rd     (bus_rd),
        .idx    (idx),
        .dec    (dec),
        .values (ctrl_out),
        .rdata  (bus_rdata)
    );

    // R1
    rdata_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_reg_alias_bank.sv
module sim_reg_alias_bank;
    localparam int NR = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [7:2]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic         bus_rd = 1'b0;
    logic [31:0]  bus_rdata;
    logic         hw_status = 1'b0;
    logic [NR*32-1:0] ctrl_out;

    int checks = 0;
    int fails  = 0;

    // Behavioural model state
    logic [31:0] m_reg [NR];
    logic        m_stat;
    logic [31:0] m_rd;

    always #2 clk = ~clk;

    reg_alias_bank u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .hw_status(hw_status), .ctrl_out(ctrl_out)
    );

    function automatic logic [31:0] impl_of(int i);
        return (32'd1 << (16 - 4 * i)) - 32'd1;
    endfunction

    function automatic logic [31:0] val_of(int i);
        return m_reg[i] | ((i == 0 && m_stat) ? 32'h8000 : 32'h0);
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Apply one bus cycle, advance the model, compare at the following negedge
    task automatic step(logic r, logic [7:0] byte_addr, logic wr, logic [31:0] wd,
                        logic rd, logic st, string req);
        rst = r; bus_addr = byte_addr[7:2]; bus_wr = wr; bus_wdata = wd;
        bus_rd = rd; hw_status = st;
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < NR; i++) m_reg[i] = '0;
            m_stat = 1'b0; m_rd = '0;
        end else begin
            int idx; int op; logic [31:0] wm; logic [31:0] mk;
            idx = int'(byte_addr[7:4]); op = int'(byte_addr[3:2]);
            if (rd) m_rd = (idx < NR && op == 0) ? val_of(idx) : 32'h0;
            if (wr && idx < NR) begin
                wm = impl_of(idx) & ((idx == 0) ? ~32'h8000 : 32'hFFFF_FFFF);
                mk = wd & wm;
                case (op)
                    0: m_reg[idx] = (m_reg[idx] & ~wm) | mk;
                    1: m_reg[idx] = m_reg[idx] & ~mk;
                    2: m_reg[idx] = m_reg[idx] | mk;
                    default: m_reg[idx] = m_reg[idx] ^ mk;
                endcase
            end
            m_stat = st;
        end
        @(negedge clk);
        for (int i = 0; i < NR; i++)
            check(req, $sformatf("reg%0d", i), ctrl_out[i*32 +: 32], val_of(i));
        check(req, "rdata", bus_rdata, m_rd);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] lfsr;
        for (int i = 0; i < NR; i++) m_reg[i] = '0;
        m_stat = 1'b0; m_rd = '0;
        @(negedge clk);
        // R1: reset, with bus activity present during reset
        step(1, 8'h00, 1, 32'hFFFF_FFFF, 1, 1, "R1");
        step(1, 8'h10, 1, 32'h1234, 0, 0, "R1");
        step(0, 8'h00, 0, 0, 1, 0, "R1");
        // R2: base write then read back
        step(0, 8'h10, 1, 32'h0000_0ABC, 0, 0, "R2");
        step(0, 8'h10, 0, 0, 1, 0, "R2");
        step(0, 8'h10, 0, 0, 0, 0, "R2");
        step(0, 8'h00, 1, 32'h0000_5A5A, 1, 0, "R2");
        // R3: clear alias
        step(0, 8'h14, 1, 32'h0000_000C, 0, 0, "R3");
        step(0, 8'h04, 1, 32'h0000_00F0, 0, 0, "R3");
        // R4: set alias
        step(0, 8'h28, 1, 32'h0000_0081, 0, 0, "R4");
        step(0, 8'h18, 1, 32'hFFFF_0000, 0, 0, "R4");
        // R5: invert alias
        step(0, 8'h1C, 1, 32'h0000_0FFF, 0, 0, "R5");
        step(0, 8'h2C, 1, 32'h0000_0003, 0, 0, "R5");
        // R6: reads of alias addresses
        step(0, 8'h14, 0, 0, 1, 0, "R6");
        step(0, 8'h18, 0, 0, 1, 0, "R6");
        step(0, 8'h0C, 0, 0, 1, 0, "R6");
        // R7: unimplemented bits ignore writes
        step(0, 8'h30, 1, 32'hFFFF_FFFF, 0, 0, "R7");
        step(0, 8'h38, 1, 32'hFFFF_FFF0, 0, 0, "R7");
        step(0, 8'h30, 0, 0, 1, 0, "R7");
        // R8: status bit follows input, immune to all writes
        step(0, 8'h00, 0, 0, 0, 1, "R8");
        step(0, 8'h00, 1, 32'h0000_0000, 0, 1, "R8");
        step(0, 8'h04, 1, 32'h0000_8000, 0, 1, "R8");
        step(0, 8'h0C, 1, 32'h0000_8000, 1, 0, "R8");
        step(0, 8'h08, 1, 32'h0000_8000, 0, 0, "R8");
        step(0, 8'h00, 0, 0, 1, 0, "R8");
        // R9: indexes beyond the bank
        step(0, 8'h40, 1, 32'hFFFF_FFFF, 0, 0, "R9");
        step(0, 8'hF8, 1, 32'hFFFF_FFFF, 0, 0, "R9");
        step(0, 8'h50, 0, 0, 1, 0, "R9");
        // R10: read and write of the same register in one cycle
        step(0, 8'h20, 1, 32'h0000_0077, 1, 0, "R10");
        step(0, 8'h20, 1, 32'h0000_0011, 1, 0, "R10");
        step(0, 8'h20, 0, 0, 1, 0, "R10");
        // Mixed stream against the model (R2)
        lfsr = 32'hACE1_1357;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(0, {1'b0, lfsr[6:0]}, lfsr[9], {lfsr[15:0], lfsr[31:16]},
                 lfsr[11], lfsr[13], "R2");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule